// File: doc/BRIEF.md
# Call and Interrupt Context Stack

This block saves and restores the execution context of a small 4-bit processor. It keeps an 8-bit stack pointer and the 15-bit program counter. It stores context frames in a nibble-wide stack that sits in data memory bank 0, reaching that memory through a single write/read port. The memory has a one-cycle read latency.

Five operations are started through a request/done handshake:
- **Subroutine call:** pushes the current program counter and status word, then jumps to a target.
- **Interrupt:** pushes the same frame, then jumps to a vector.
- **Return:** pops the frame back.
- **Bank-select push and pop:** save or restore the memory-bank and register-bank select values.

Outside an operation, the sequencer may write the stack pointer and load the program counter directly.

A program counter and status word frame needs six nibbles, so the top bit of the first nibble is a spare zero. The pointer decrements before each write, which means a pointer of 00H places the first nibble at 0FFH. A pop reads upward from the pointer, in exactly the reverse order of the push.

Top module: `ctx_stack`

## Requirements
- R1: A write through `sp_we_i` while idle stores `sp_wdata_i` with bit 0 forced to zero, and `sp_o` shows the result on the next cycle.
- R2: A call or interrupt makes six writes on six consecutive cycles, starting the cycle after the request is accepted. The write addresses are bank 0 offsets SP-1 down to SP-6, and their upper four address bits are zero. The data, in write order, is {0,PC[14:12]}, PC[11:8], PC[7:4], PC[3:0], PSW[7:4], PSW[3:0]. Reads and writes never occur in the same cycle.
- R3: Pointer arithmetic wraps modulo 256. With SP=00H the first nibble goes to 0FFH, and with SP=02H the writes go to 01H, 00H, 0FFH, 0FEH, 0FDH, 0FCH.
- R4: After a call, the pointer has dropped by 6 and `pc_o` equals `tgt_i`. After an interrupt, the pointer has dropped by 6 and `pc_o` equals {0,`vec_i`}. In both cases `tgt_i` and `vec_i` are sampled at acceptance.
- R5: A return reads offsets SP up to SP+5, issuing one read per cycle. It restores `pc_o` and `psw_o` from those nibbles and raises the pointer by 6.
- R6: A bank-select push writes `smb_i` to SP-1 and `srb_i` to SP-2 and lowers the pointer by 2. A bank-select pop restores `srb_o` from SP and `smb_o` from SP+1 and raises the pointer by 2.
- R7: `done_o` is a one-cycle pulse. For a push of N nibbles it is high in cycle N after acceptance; for a pop of N nibbles it is high in cycle N+1. When it is high, `busy_o` is already low and `sp_o` and `pc_o` hold their new values.
- R8: While `busy_o` is high, the block ignores `req_i`, `sp_we_i` and `pc_ld_i`. It also ignores a request whose `op_i` is not one of 0 (call), 1 (interrupt), 2 (return), 3 (bank-select push) or 4 (bank-select pop).
- R9: After reset, `pc_o` equals the reset vector (0), `busy_o` and `done_o` are low, and no memory strobe is active.
- R10: `pc_ld_i` while idle loads `pc_nxt_i` into `pc_o` on the next cycle.
- R11: Bit 0 of the stack pointer is zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an operation |
| op_i | input | 3 | Operation code (0 call, 1 interrupt, 2 return, 3 bank push, 4 bank pop) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_we_i | input | 1 | Stack pointer write |
| sp_wdata_i | input | 8 | Stack pointer write value |
| sp_o | output | 8 | Stack pointer |
| pc_ld_i | input | 1 | Program counter load |
| pc_nxt_i | input | 15 | Program counter load value |
| tgt_i | input | 15 | Call target |
| vec_i | input | 14 | Interrupt vector |
| pc_o | output | 15 | Program counter |
| psw_i | input | 8 | Status word to save |
| psw_o | output | 8 | Restored status word |
| smb_i | input | 4 | Memory-bank select to save |
| srb_i | input | 4 | Register-bank select to save |
| smb_o | output | 4 | Restored memory-bank select |
| srb_o | output | 4 | Restored register-bank select |
| ram_we_o | output | 1 | Memory write strobe |
| ram_re_o | output | 1 | Memory read strobe |
| ram_addr_o | output | 12 | Memory address (bank, offset) |
| ram_wdata_o | output | 4 | Memory write nibble |
| ram_rdata_i | input | 4 | Memory read nibble, one cycle after the read strobe |

## Verification
The bench builds the block with its defaults: a 15-bit program counter, an 8-bit pointer, 4-bit nibbles and a zero reset vector. With a 15-bit program counter split into four nibbles, the spare bit lands in the first nibble written, so the exact nibble order is visible at the memory port. With an 8-bit pointer, a frame pushed from 02H crosses the 00H/0FFH boundary within one operation. Nested call, bank-select and interrupt frames are popped back in reverse order, which shows that each frame restores to the value it saved.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  typedef enum logic [2:0] {
    OP_CALL    = 3'd0,
    OP_INTR    = 3'd1,
    OP_RET     = 3'd2,
    OP_PUSH_SB = 3'd3,
    OP_POP_SB  = 3'd4
  } op_e;

  localparam logic [2:0] OP_LAST = 3'd4;
endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int unsigned SP_W  = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SP_W-1:0]  wr_val_i,
  input  logic             mv_en_i,
  input  logic             mv_dn_i,
  input  logic [CNT_W-1:0] mv_amt_i,
  output logic [SP_W-1:0]  sp_o
);
  logic [SP_W-1:0] sp_q;

  // amounts are always even, so bit 0 never moves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else if (mv_en_i) sp_q <= mv_dn_i ? sp_q - SP_W'(mv_amt_i) : sp_q + SP_W'(mv_amt_i);
    else if (wr_en_i) sp_q <= {wr_val_i[SP_W-1:1], 1'b0};
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/ctx_pc_reg.sv
module ctx_pc_reg #(
  parameter int unsigned PC_W    = 15,
  parameter logic [PC_W-1:0] RST_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_en_i,
  input  logic [PC_W-1:0] ld_val_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_VEC;
    else if (ld_en_i) pc_q <= ld_val_i;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_stack_pkg::*;
#(
  parameter int unsigned NIB_W      = 4,
  parameter int unsigned SP_W       = 8,
  parameter int unsigned BANK_W     = 4,
  parameter int unsigned PC_W       = 15,
  parameter int unsigned VEC_W      = 14,
  parameter int unsigned PSW_W      = 8,
  parameter int unsigned FRAME_NIBS = 6,
  parameter int unsigned SB_NIBS    = 2,
  parameter int unsigned CNT_W      = 3,
  localparam int unsigned FRAME_W   = FRAME_NIBS * NIB_W,
  localparam int unsigned ADDR_W    = BANK_W + SP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [2:0]         op_i,
  input  logic [SP_W-1:0]    sp_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PSW_W-1:0]   psw_i,
  input  logic [NIB_W-1:0]   smb_i,
  input  logic [NIB_W-1:0]   srb_i,
  input  logic [PC_W-1:0]    tgt_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               finish_o,
  output op_e                op_o,
  output logic [FRAME_W-1:0] pop_data_o,
  output logic [PC_W-1:0]    jump_o,
  output logic               ram_we_o,
  output logic               ram_re_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [NIB_W-1:0]   ram_wdata_o,
  input  logic [NIB_W-1:0]   ram_rdata_i
);
  logic               busy_q, done_q;
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q, n_nib;
  logic [FRAME_W-1:0] frame_q, shift_q, push_frame;
  logic [PC_W-1:0]    tgt_q;
  logic [SP_W-1:0]    off;
  logic               is_pop, is_sb, accept, last_push, last_pop;

  assign is_pop = (op_q == OP_RET) || (op_q == OP_POP_SB);
  assign is_sb  = (op_q == OP_PUSH_SB) || (op_q == OP_POP_SB);
  assign n_nib  = is_sb ? CNT_W'(SB_NIBS) : CNT_W'(FRAME_NIBS);
  assign accept = req_i && !busy_q && (op_i <= OP_LAST);

  assign last_push = busy_q && !is_pop && (cnt_q == n_nib - CNT_W'(1));
  assign last_pop  = busy_q && is_pop && (cnt_q == n_nib);
  assign finish_o  = last_push || last_pop;

  // frame image, first nibble to write in the top position
  assign push_frame = (op_i == OP_PUSH_SB)
      ? FRAME_W'({smb_i, srb_i}) << (FRAME_W - SB_NIBS * NIB_W)
      : FRAME_W'({pc_i, psw_i});

  assign off         = is_pop ? sp_i + SP_W'(cnt_q) : sp_i - SP_W'(cnt_q) - SP_W'(1);
  assign ram_we_o    = busy_q && !is_pop;
  assign ram_re_o    = busy_q && is_pop && (cnt_q < n_nib);
  assign ram_addr_o  = {BANK_W'(0), off};
  assign ram_wdata_o = frame_q[FRAME_W-1 -: NIB_W];
  assign pop_data_o  = {ram_rdata_i, shift_q[FRAME_W-1:NIB_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= OP_CALL;
      cnt_q   <= '0;
      frame_q <= '0;
      shift_q <= '0;
      tgt_q   <= '0;
    end else begin
      done_q <= finish_o;
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= op_e'(op_i);
        cnt_q   <= '0;
        frame_q <= push_frame;
        shift_q <= '0;
        tgt_q   <= (op_i == OP_INTR) ? PC_W'(vec_i) : tgt_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (!is_pop) frame_q <= frame_q << NIB_W;
        else if (cnt_q != '0) shift_q <= pop_data_o;
        if (finish_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;
  assign jump_o = tgt_q;
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import ctx_stack_pkg::*;
#(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned SP_W   = 8,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned PC_W   = 15,
  parameter int unsigned VEC_W  = 14,
  parameter int unsigned PSW_W  = 8,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  localparam int unsigned ADDR_W     = BANK_W + SP_W,
  localparam int unsigned FRAME_NIBS = (PC_W + PSW_W + NIB_W - 1) / NIB_W,
  localparam int unsigned SB_NIBS    = 2,
  localparam int unsigned FRAME_W    = FRAME_NIBS * NIB_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_NIBS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic              sp_we_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  output logic [SP_W-1:0]   sp_o,
  input  logic              pc_ld_i,
  input  logic [PC_W-1:0]   pc_nxt_i,
  input  logic [PC_W-1:0]   tgt_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [PC_W-1:0]   pc_o,
  input  logic [PSW_W-1:0]  psw_i,
  output logic [PSW_W-1:0]  psw_o,
  input  logic [NIB_W-1:0]  smb_i,
  input  logic [NIB_W-1:0]  srb_i,
  output logic [NIB_W-1:0]  smb_o,
  output logic [NIB_W-1:0]  srb_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [NIB_W-1:0]  ram_wdata_o,
  input  logic [NIB_W-1:0]  ram_rdata_i
);
  logic               finish;
  op_e                op_cur;
  logic [FRAME_W-1:0] pop_data;
  logic [PC_W-1:0]    jump;
  logic               is_pop, is_sb, pc_ld_en;
  logic [PC_W-1:0]    pc_ld_val;

  ctx_seq #(
    .NIB_W(NIB_W), .SP_W(SP_W), .BANK_W(BANK_W), .PC_W(PC_W), .VEC_W(VEC_W),
    .PSW_W(PSW_W), .FRAME_NIBS(FRAME_NIBS), .SB_NIBS(SB_NIBS), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .op_i,
    .sp_i(sp_o), .pc_i(pc_o), .psw_i, .smb_i, .srb_i, .tgt_i, .vec_i,
    .busy_o, .done_o, .finish_o(finish), .op_o(op_cur), .pop_data_o(pop_data),
    .jump_o(jump), .ram_we_o, .ram_re_o, .ram_addr_o, .ram_wdata_o, .ram_rdata_i
  );

  assign is_pop = (op_cur == OP_RET) || (op_cur == OP_POP_SB);
  assign is_sb  = (op_cur == OP_PUSH_SB) || (op_cur == OP_POP_SB);

  ctx_sp_reg #(.SP_W(SP_W), .CNT_W(CNT_W)) u_sp (
    .clk_i, .rst_ni,
    .wr_en_i(sp_we_i && !busy_o), .wr_val_i(sp_wdata_i),
    .mv_en_i(finish), .mv_dn_i(!is_pop),
    .mv_amt_i(is_sb ? CNT_W'(SB_NIBS) : CNT_W'(FRAME_NIBS)),
    .sp_o
  );

  always_comb begin
    pc_ld_en  = 1'b0;
    pc_ld_val = pc_nxt_i;
    if (finish) begin
      if (op_cur == OP_CALL || op_cur == OP_INTR) begin
        pc_ld_en  = 1'b1;
        pc_ld_val = jump;
      end else if (op_cur == OP_RET) begin
        pc_ld_en  = 1'b1;
        pc_ld_val = pop_data[PSW_W +: PC_W];
      end
    end else if (pc_ld_i && !busy_o) begin
      pc_ld_en = 1'b1;
    end
  end

  ctx_pc_reg #(.PC_W(PC_W), .RST_VEC(RST_VEC)) u_pc (
    .clk_i, .rst_ni, .ld_en_i(pc_ld_en), .ld_val_i(pc_ld_val), .pc_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_o <= '0;
      smb_o <= '0;
      srb_o <= '0;
    end else if (finish) begin
      if (op_cur == OP_RET) psw_o <= pop_data[PSW_W-1:0];
      if (op_cur == OP_POP_SB) begin
        smb_o <= pop_data[FRAME_W-1 -: NIB_W];
        srb_o <= pop_data[FRAME_W-NIB_W-1 -: NIB_W];
      end
    end
  end
endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk #(
  parameter int unsigned SP_W   = 8,
  parameter int unsigned BANK_W = 4,
  localparam int unsigned ADDR_W = BANK_W + SP_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [SP_W-1:0]   sp_o,
  input logic              ram_we_o,
  input logic              ram_re_o,
  input logic [ADDR_W-1:0] ram_addr_o
);
  p_sp_even_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_o[0] == 1'b0);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_bank0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || ram_re_o) |-> (ram_addr_o[ADDR_W-1:SP_W] == '0));

  p_no_dual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));

  p_push_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o)) |->
      (ram_addr_o[SP_W-1:0] == $past(ram_addr_o[SP_W-1:0]) - SP_W'(1)));

  p_pop_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && $past(ram_re_o)) |->
      (ram_addr_o[SP_W-1:0] == $past(ram_addr_o[SP_W-1:0]) + SP_W'(1)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ram_we_o && !ram_re_o));

  p_sp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(sp_o) || done_o));
endmodule

bind ctx_stack ctx_stack_chk #(.SP_W(SP_W), .BANK_W(BANK_W)) u_chk (.*);

// File: tb/ctx_stack_test.sv
module ctx_stack_test;
  import ctx_stack_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        busy_o, done_o;
  logic        sp_we_i = 1'b0;
  logic [7:0]  sp_wdata_i = '0;
  logic [7:0]  sp_o;
  logic        pc_ld_i = 1'b0;
  logic [14:0] pc_nxt_i = '0;
  logic [14:0] tgt_i = '0;
  logic [13:0] vec_i = '0;
  logic [14:0] pc_o;
  logic [7:0]  psw_i = '0;
  logic [7:0]  psw_o;
  logic [3:0]  smb_i = '0, srb_i = '0, smb_o, srb_o;
  logic        ram_we_o, ram_re_o;
  logic [11:0] ram_addr_o;
  logic [3:0]  ram_wdata_o;
  logic [3:0]  ram_rdata_i;

  ctx_stack uut (.*);

  always #2 clk_i = ~clk_i;

  // bank 0 memory model, one-cycle read latency
  logic [3:0] mem [256];
  logic [3:0] rd_q = '0;
  always @(posedge clk_i) begin
    if (ram_we_o) mem[ram_addr_o[7:0]] <= ram_wdata_o;
    if (ram_re_o) rd_q <= mem[ram_addr_o[7:0]];
  end
  assign ram_rdata_i = rd_q;

  logic [11:0] wa [64];
  logic [3:0]  wd [64];
  int wn = 0;
  int dn = 0;
  always @(posedge clk_i) begin
    if (ram_we_o) begin
      wa[wn % 64] <= ram_addr_o;
      wd[wn % 64] <= ram_wdata_o;
      wn <= wn + 1;
    end
    if (done_o) dn <= dn + 1;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [14:0] a, input logic [7:0] d, output int lat);
    @(negedge clk_i);
    op_i = op; req_i = 1'b1;
    tgt_i = a; vec_i = a[13:0]; psw_i = d; smb_i = d[7:4]; srb_i = d[3:0];
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(posedge clk_i);
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic set_sp(input logic [7:0] v);
    @(negedge clk_i);
    sp_we_i = 1'b1; sp_wdata_i = v;
    @(negedge clk_i);
    sp_we_i = 1'b0;
  endtask

  task automatic set_pc(input logic [14:0] v);
    @(negedge clk_i);
    pc_ld_i = 1'b1; pc_nxt_i = v;
    @(negedge clk_i);
    pc_ld_i = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [14:0] a;
    logic [7:0]  d;
    logic [7:0]  sp;
    logic [14:0] pc;
    logic [7:0]  rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{op: 3'd0, a: 15'h2000, d: 8'hA5, sp: 8'hFA, pc: 15'h2000, rd: 8'h00},
    '{op: 3'd3, a: 15'h0000, d: 8'h32, sp: 8'hF8, pc: 15'h2000, rd: 8'h00},
    '{op: 3'd1, a: 15'h0024, d: 8'h3C, sp: 8'hF2, pc: 15'h0024, rd: 8'h00},
    '{op: 3'd2, a: 15'h0000, d: 8'h00, sp: 8'hF8, pc: 15'h2000, rd: 8'h3C},
    '{op: 3'd4, a: 15'h0000, d: 8'h00, sp: 8'hFA, pc: 15'h2000, rd: 8'h32},
    '{op: 3'd2, a: 15'h0000, d: 8'h00, sp: 8'h00, pc: 15'h1234, rd: 8'hA5}
  };

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat, w0, d0;
    logic [7:0] sp0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(pc_o == 15'h0, "R9 reset pc", 32'(pc_o), 0);
    chk(!busy_o && !done_o, "R9 reset busy/done", {busy_o, done_o}, 0);
    chk(!ram_we_o && !ram_re_o, "R9 reset strobes", {ram_we_o, ram_re_o}, 0);
    rst_ni = 1'b1;

    // R1 pointer write forces bit 0
    set_sp(8'h01);
    chk(sp_o == 8'h00, "R1 sp write 01", 32'(sp_o), 32'h00);
    set_sp(8'hA7);
    chk(sp_o == 8'hA6, "R1 sp write A7", 32'(sp_o), 32'hA6);
    set_sp(8'h00);
    // R10 direct pc load
    set_pc(15'h1234);
    chk(pc_o == 15'h1234, "R10 pc load", 32'(pc_o), 32'h1234);

    // table walk: nested frames popped in reverse
    for (int i = 0; i < NV; i++) begin
      int exp_lat;
      exp_lat = (TBL[i].op == 3'd0 || TBL[i].op == 3'd1) ? 6 :
                (TBL[i].op == 3'd3) ? 2 : (TBL[i].op == 3'd2) ? 7 : 3;
      do_op(TBL[i].op, TBL[i].a, TBL[i].d, lat);
      chk(lat == exp_lat, "R7 done latency", 32'(lat), 32'(exp_lat));
      chk(!busy_o, "R7 idle at done", 32'(busy_o), 0);
      chk(sp_o == TBL[i].sp, "R4/R5/R6 sp after op", 32'(sp_o), 32'(TBL[i].sp));
      chk(pc_o == TBL[i].pc, "R4/R5 pc after op", 32'(pc_o), 32'(TBL[i].pc));
      if (TBL[i].op == 3'd2)
        chk(psw_o == TBL[i].rd, "R5 psw restore", 32'(psw_o), 32'(TBL[i].rd));
      if (TBL[i].op == 3'd4)
        chk({smb_o, srb_o} == TBL[i].rd, "R6 bank restore", 32'({smb_o, srb_o}), 32'(TBL[i].rd));
      @(negedge clk_i);
      chk(!done_o, "R7 single pulse", 32'(done_o), 0);
    end

    // R2 R3 wrap across 00H with exact nibble order
    set_sp(8'h02);
    set_pc(15'h5ABC);
    w0 = wn;
    do_op(3'd0, 15'h0100, 8'h96, lat);
    begin
      logic [7:0] ea [6];
      logic [3:0] ed [6];
      ea = '{8'h01, 8'h00, 8'hFF, 8'hFE, 8'hFD, 8'hFC};
      ed = '{4'h5, 4'hA, 4'hB, 4'hC, 4'h9, 4'h6};
      chk(wn - w0 == 6, "R2 write count", 32'(wn - w0), 6);
      for (int k = 0; k < 6; k++) begin
        chk(wa[(w0 + k) % 64] == {4'h0, ea[k]}, "R3 wrap address", 32'(wa[(w0 + k) % 64]), 32'(ea[k]));
        chk(wd[(w0 + k) % 64] == ed[k], "R2 nibble order", 32'(wd[(w0 + k) % 64]), 32'(ed[k]));
      end
    end
    chk(sp_o == 8'hFC, "R3 sp after wrap", 32'(sp_o), 32'hFC);
    chk(pc_o == 15'h0100, "R4 call target", 32'(pc_o), 32'h0100);
    do_op(3'd2, 15'h0, 8'h0, lat);
    chk(pc_o == 15'h5ABC, "R5 return across wrap", 32'(pc_o), 32'h5ABC);
    chk(psw_o == 8'h96, "R5 psw across wrap", 32'(psw_o), 32'h96);
    chk(sp_o == 8'h02, "R3 sp back", 32'(sp_o), 32'h02);

    // R4 interrupt clears bit 14
    set_pc(15'h7FFE);
    do_op(3'd1, 15'h3FFF, 8'h11, lat);
    chk(pc_o == 15'h3FFF, "R4 interrupt vector", 32'(pc_o), 32'h3FFF);
    do_op(3'd2, 15'h0, 8'h0, lat);
    chk(pc_o == 15'h7FFE, "R5 return bit 14", 32'(pc_o), 32'h7FFE);

    // R8 inputs ignored while busy
    set_sp(8'h00);
    d0 = dn;
    @(negedge clk_i);
    op_i = 3'd0; tgt_i = 15'h0200; psw_i = 8'h44; req_i = 1'b1;
    @(negedge clk_i);
    op_i = 3'd4; sp_we_i = 1'b1; sp_wdata_i = 8'h40; pc_ld_i = 1'b1; pc_nxt_i = 15'h7777;
    @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; sp_we_i = 1'b0; pc_ld_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk(sp_o == 8'hFA, "R8 sp write ignored", 32'(sp_o), 32'hFA);
    chk(pc_o == 15'h0200, "R8 pc load ignored", 32'(pc_o), 32'h0200);
    chk(dn - d0 == 1, "R8 request ignored", 32'(dn - d0), 1);
    chk(!busy_o, "R8 idle after", 32'(busy_o), 0);

    // R8 undefined op code
    sp0 = sp_o;
    d0 = dn;
    @(negedge clk_i);
    op_i = 3'd7; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(!busy_o && !ram_we_o && !ram_re_o, "R8 bad op no start", {busy_o, ram_we_o, ram_re_o}, 0);
    repeat (4) @(negedge clk_i);
    chk(dn == d0 && sp_o == sp0, "R8 bad op no effect", 32'(sp_o), 32'(sp0));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule